// File: doc/BRIEF.md
# Clock Tree Frequency Calculator

This block answers the question "how many hertz does clock X run at right now" for a small derived-clock tree fed by a fixed 24 MHz reference. A requester presents a clock identifier together with a snapshot of the configuration fields: the system PLL multiplier select, two fractional-tap fraction fields, a two-bit source select for the peripheral root, and three post-divider fields. The block then walks the tree: PLL, optional fractional tap, source mux, and a chain of (1+N) post-dividers. It returns the frequency as a 32-bit integer and an error flag.

All division runs on one shared restoring divider that produces one quotient bit per clock. A full walk costs a few hundred cycles, so the block suits slow paths such as firmware-visible timer setup. It does not suit per-cycle use. Requests enter on a valid/ready pair. `req_ready` is high only while the calculator is idle. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. While the calculator is busy, `req_ready` stays low, and any request held or pulsed during that time is not taken. The answer leaves as a one-cycle `rsp_valid` strobe with no back-pressure, so the consumer must capture `rsp_freq` and `rsp_err` in that cycle.

Top module: `clkcalc_top`

## Requirements
- R1: With source code 0 and zero post-divider fields, identifier 1 (IPG) returns 480,000,000 when `cfg_pll_mul22` is 0 and 528,000,000 when it is 1, that is, 24 MHz times 20 or times 22.
- R2: A fractional tap yields (PLL Hz × 18) / fraction, with the quotient truncated toward zero.
- R3: Source code 0 selects the PLL, code 1 selects tap 2 (`cfg_frac2`), code 2 selects tap 0 (`cfg_frac0`), and code 3 selects tap 2 halved (integer shift).
- R4: The bus clock is the source clock divided by (1 + `cfg_bus_div`). Identifier 1 (IPG) returns the bus clock divided by (1 + `cfg_ipg_div`). Identifier 2 (PER) returns the IPG value divided again by (1 + `cfg_per_div`). Every division truncates.
- R5: Identifier 0 returns 0, identifier 3 returns 24,000,000 and identifier 4 returns 3,000,000. All three return with `rsp_err` low.
- R6: Identifiers 5, 6 and 7 return 0 with `rsp_err` high.
- R7: If the selected tap has a fraction of 0, the result is 0 with `rsp_err` high and the block does not stall. A zero fraction on a tap that is not selected has no effect.
- R8: Intermediate values are 64 bits wide, and `rsp_freq` carries the low 32 bits of the final value.
- R9: `req_ready` is low from the cycle after acceptance until the response has been sent. A request offered while `req_ready` is low is ignored. `rsp_valid` is high for exactly one cycle per accepted request.
- R10: The configuration fields and the identifier are captured at acceptance, so changes to them while the calculator is busy do not affect the result.
- R11: After reset, `req_ready` is 1, `rsp_valid` is 0, `rsp_freq` is 0 and `rsp_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Calculator idle, request can be taken |
| req_clk_id | input | 3 | Clock identifier (0 none, 1 IPG, 2 PER, 3 reference, 4 reference/8) |
| cfg_pll_mul22 | input | 1 | PLL multiplier select: 1 = ×22, 0 = ×20 |
| cfg_frac0 | input | FRAC_W | Fraction of tap 0 |
| cfg_frac2 | input | FRAC_W | Fraction of tap 2 |
| cfg_src_sel | input | 2 | Peripheral root source code |
| cfg_bus_div | input | DIV_W | Bus post-divider field N, divide by N+1 |
| cfg_ipg_div | input | DIV_W | IPG post-divider field |
| cfg_per_div | input | DIV_W | PER post-divider field |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_freq | output | 32 | Frequency in Hz, low 32 bits |
| rsp_err | output | 1 | Unsupported identifier or zero fraction |

## Verification
The checker assumes that the requester keeps `req_clk_id` stable in the accept cycle and that no more than one request is outstanding. The handshake itself guarantees the second condition. Its identifier-based properties rely on the identifier captured at acceptance. The bench drives every request at the falling edge, holds it for exactly one rising edge while `req_ready` is high, and then drops it. The one exception is the deliberate busy-time probes, which must leave the response untouched. Those probes also change the configuration fields mid-walk, to show that the snapshot taken at acceptance is the one used.

// File: rtl/clkcalc_pkg.sv
package clkcalc_pkg;

  localparam logic [31:0] REF_HZ      = 32'd24000000;
  localparam logic [31:0] REF_DIV8_HZ = 32'd3000000;
  localparam logic [31:0] PLL_MUL_LO  = 32'd20;
  localparam logic [31:0] PLL_MUL_HI  = 32'd22;
  localparam logic [31:0] TAP_MUL     = 32'd18;

  localparam logic [2:0] CID_NONE      = 3'd0;
  localparam logic [2:0] CID_IPG       = 3'd1;
  localparam logic [2:0] CID_PER       = 3'd2;
  localparam logic [2:0] CID_XTAL      = 3'd3;
  localparam logic [2:0] CID_XTAL_DIV8 = 3'd4;

  localparam logic [1:0] SRC_PLL       = 2'd0;
  localparam logic [1:0] SRC_TAP2      = 2'd1;
  localparam logic [1:0] SRC_TAP0      = 2'd2;
  localparam logic [1:0] SRC_TAP2_HALF = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DISPATCH,
    ST_LAUNCH,
    ST_WAIT,
    ST_OUT
  } seq_state_e;

  typedef enum logic [1:0] {
    STEP_TAP,
    STEP_BUS,
    STEP_IPG,
    STEP_PER
  } walk_step_e;

endpackage

// File: rtl/clkcalc_divider.sv
// Restoring unsigned divider, one quotient bit per cycle.
module clkcalc_divider #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         done,
  output logic [W-1:0] quotient
);
  localparam int CNT_W = $clog2(W + 1);

  logic [W-1:0]     rem_q;
  logic [W-1:0]     quo_q;
  logic [W-1:0]     den_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  logic [W:0] shifted;
  logic [W:0] diff;
  logic       fits;

  always_comb begin
    shifted = {rem_q, quo_q[W-1]};
    diff    = shifted - {1'b0, den_q};
    fits    = (shifted >= {1'b0, den_q});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quo_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done   <= 1'b0;
    end else if (start) begin
      rem_q  <= '0;
      quo_q  <= dividend;
      den_q  <= divisor;
      cnt_q  <= CNT_W'(W);
      busy_q <= 1'b1;
      done   <= 1'b0;
    end else if (busy_q) begin
      rem_q <= fits ? diff[W-1:0] : shifted[W-1:0];
      quo_q <= {quo_q[W-2:0], fits};
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) begin
        busy_q <= 1'b0;
        done   <= 1'b1;
      end
    end else begin
      done <= 1'b0;
    end
  end

  assign quotient = quo_q;

endmodule

// File: rtl/clkcalc_src.sv
// PLL rate and fractional-tap selection for the peripheral root.
module clkcalc_src
  import clkcalc_pkg::*;
#(
  parameter int FRAC_W = 6,
  parameter int WIDE_W = 64
) (
  input  logic              pll_mul22,
  input  logic [1:0]        src_sel,
  input  logic [FRAC_W-1:0] frac0,
  input  logic [FRAC_W-1:0] frac2,
  output logic [WIDE_W-1:0] pll_hz,
  output logic [WIDE_W-1:0] tap_num,
  output logic              tap_used,
  output logic              tap_halve,
  output logic [FRAC_W-1:0] tap_frac
);
  localparam logic [31:0] PLL_LO_HZ = REF_HZ * PLL_MUL_LO;
  localparam logic [31:0] PLL_HI_HZ = REF_HZ * PLL_MUL_HI;

  always_comb begin
    pll_hz  = pll_mul22 ? WIDE_W'(PLL_HI_HZ) : WIDE_W'(PLL_LO_HZ);
    tap_num = pll_hz * WIDE_W'(TAP_MUL);
    case (src_sel)
      SRC_TAP2: begin
        tap_used  = 1'b1;
        tap_halve = 1'b0;
        tap_frac  = frac2;
      end
      SRC_TAP0: begin
        tap_used  = 1'b1;
        tap_halve = 1'b0;
        tap_frac  = frac0;
      end
      SRC_TAP2_HALF: begin
        tap_used  = 1'b1;
        tap_halve = 1'b1;
        tap_frac  = frac2;
      end
      default: begin
        tap_used  = 1'b0;
        tap_halve = 1'b0;
        tap_frac  = '0;
      end
    endcase
  end

endmodule

// File: rtl/clkcalc_seq.sv
// Request capture and tree walk over the shared divider.
module clkcalc_seq
  import clkcalc_pkg::*;
#(
  parameter int FRAC_W = 6,
  parameter int DIV_W  = 3,
  parameter int WIDE_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_clk_id,
  input  logic              cfg_pll_mul22,
  input  logic [FRAC_W-1:0] cfg_frac0,
  input  logic [FRAC_W-1:0] cfg_frac2,
  input  logic [1:0]        cfg_src_sel,
  input  logic [DIV_W-1:0]  cfg_bus_div,
  input  logic [DIV_W-1:0]  cfg_ipg_div,
  input  logic [DIV_W-1:0]  cfg_per_div,
  output logic              snap_mul22,
  output logic [1:0]        snap_src_sel,
  output logic [FRAC_W-1:0] snap_frac0,
  output logic [FRAC_W-1:0] snap_frac2,
  input  logic [WIDE_W-1:0] pll_hz,
  input  logic [WIDE_W-1:0] tap_num,
  input  logic              tap_used,
  input  logic              tap_halve,
  input  logic [FRAC_W-1:0] tap_frac,
  output logic              div_start,
  output logic [WIDE_W-1:0] div_dividend,
  output logic [WIDE_W-1:0] div_divisor,
  input  logic              div_done,
  input  logic [WIDE_W-1:0] div_quot,
  output logic              rsp_valid,
  output logic [31:0]       rsp_freq,
  output logic              rsp_err
);
  seq_state_e        state;
  walk_step_e        step;
  logic [2:0]        id_q;
  logic [DIV_W-1:0]  bus_q;
  logic [DIV_W-1:0]  ipg_q;
  logic [DIV_W-1:0]  per_q;
  logic [WIDE_W-1:0] acc_q;

  assign req_ready    = (state == ST_IDLE);
  assign rsp_valid    = (state == ST_OUT);
  assign div_start    = (state == ST_LAUNCH);
  assign div_dividend = acc_q;

  always_comb begin
    case (step)
      STEP_TAP: div_divisor = WIDE_W'(tap_frac);
      STEP_BUS: div_divisor = WIDE_W'(bus_q) + WIDE_W'(1);
      STEP_IPG: div_divisor = WIDE_W'(ipg_q) + WIDE_W'(1);
      default:  div_divisor = WIDE_W'(per_q) + WIDE_W'(1);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      step         <= STEP_TAP;
      id_q         <= '0;
      bus_q        <= '0;
      ipg_q        <= '0;
      per_q        <= '0;
      snap_mul22   <= 1'b0;
      snap_src_sel <= '0;
      snap_frac0   <= '0;
      snap_frac2   <= '0;
      acc_q        <= '0;
      rsp_freq     <= '0;
      rsp_err      <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            id_q         <= req_clk_id;
            snap_mul22   <= cfg_pll_mul22;
            snap_src_sel <= cfg_src_sel;
            snap_frac0   <= cfg_frac0;
            snap_frac2   <= cfg_frac2;
            bus_q        <= cfg_bus_div;
            ipg_q        <= cfg_ipg_div;
            per_q        <= cfg_per_div;
            state        <= ST_DISPATCH;
          end
        end
        ST_DISPATCH: begin
          rsp_err <= 1'b0;
          case (id_q)
            CID_NONE: begin
              rsp_freq <= '0;
              state    <= ST_OUT;
            end
            CID_XTAL: begin
              rsp_freq <= REF_HZ;
              state    <= ST_OUT;
            end
            CID_XTAL_DIV8: begin
              rsp_freq <= REF_DIV8_HZ;
              state    <= ST_OUT;
            end
            CID_IPG, CID_PER: begin
              if (!tap_used) begin
                acc_q <= pll_hz;
                step  <= STEP_BUS;
                state <= ST_LAUNCH;
              end else if (tap_frac == '0) begin
                rsp_freq <= '0;
                rsp_err  <= 1'b1;
                state    <= ST_OUT;
              end else begin
                acc_q <= tap_num;
                step  <= STEP_TAP;
                state <= ST_LAUNCH;
              end
            end
            default: begin
              rsp_freq <= '0;
              rsp_err  <= 1'b1;
              state    <= ST_OUT;
            end
          endcase
        end
        ST_LAUNCH: state <= ST_WAIT;
        ST_WAIT: begin
          if (div_done) begin
            case (step)
              STEP_TAP: begin
                acc_q <= tap_halve ? (div_quot >> 1) : div_quot;
                step  <= STEP_BUS;
                state <= ST_LAUNCH;
              end
              STEP_BUS: begin
                acc_q <= div_quot;
                step  <= STEP_IPG;
                state <= ST_LAUNCH;
              end
              STEP_IPG: begin
                if (id_q == CID_PER) begin
                  acc_q <= div_quot;
                  step  <= STEP_PER;
                  state <= ST_LAUNCH;
                end else begin
                  rsp_freq <= div_quot[31:0];
                  state    <= ST_OUT;
                end
              end
              default: begin
                rsp_freq <= div_quot[31:0];
                state    <= ST_OUT;
              end
            endcase
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/clkcalc_top.sv
module clkcalc_top #(
  parameter int FRAC_W = 6,
  parameter int DIV_W  = 3,
  parameter int WIDE_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_clk_id,
  input  logic              cfg_pll_mul22,
  input  logic [FRAC_W-1:0] cfg_frac0,
  input  logic [FRAC_W-1:0] cfg_frac2,
  input  logic [1:0]        cfg_src_sel,
  input  logic [DIV_W-1:0]  cfg_bus_div,
  input  logic [DIV_W-1:0]  cfg_ipg_div,
  input  logic [DIV_W-1:0]  cfg_per_div,
  output logic              rsp_valid,
  output logic [31:0]       rsp_freq,
  output logic              rsp_err
);
  logic              snap_mul22;
  logic [1:0]        snap_src_sel;
  logic [FRAC_W-1:0] snap_frac0;
  logic [FRAC_W-1:0] snap_frac2;
  logic [WIDE_W-1:0] pll_hz;
  logic [WIDE_W-1:0] tap_num;
  logic              tap_used;
  logic              tap_halve;
  logic [FRAC_W-1:0] tap_frac;
  logic              div_start;
  logic [WIDE_W-1:0] div_dividend;
  logic [WIDE_W-1:0] div_divisor;
  logic              div_done;
  logic [WIDE_W-1:0] div_quot;

  clkcalc_src #(.FRAC_W(FRAC_W), .WIDE_W(WIDE_W)) u_src (
    .pll_mul22 (snap_mul22),
    .src_sel   (snap_src_sel),
    .frac0     (snap_frac0),
    .frac2     (snap_frac2),
    .pll_hz    (pll_hz),
    .tap_num   (tap_num),
    .tap_used  (tap_used),
    .tap_halve (tap_halve),
    .tap_frac  (tap_frac)
  );

  clkcalc_seq #(.FRAC_W(FRAC_W), .DIV_W(DIV_W), .WIDE_W(WIDE_W)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_clk_id    (req_clk_id),
    .cfg_pll_mul22 (cfg_pll_mul22),
    .cfg_frac0     (cfg_frac0),
    .cfg_frac2     (cfg_frac2),
    .cfg_src_sel   (cfg_src_sel),
    .cfg_bus_div   (cfg_bus_div),
    .cfg_ipg_div   (cfg_ipg_div),
    .cfg_per_div   (cfg_per_div),
    .snap_mul22    (snap_mul22),
    .snap_src_sel  (snap_src_sel),
    .snap_frac0    (snap_frac0),
    .snap_frac2    (snap_frac2),
    .pll_hz        (pll_hz),
    .tap_num       (tap_num),
    .tap_used      (tap_used),
    .tap_halve     (tap_halve),
    .tap_frac      (tap_frac),
    .div_start     (div_start),
    .div_dividend  (div_dividend),
    .div_divisor   (div_divisor),
    .div_done      (div_done),
    .div_quot      (div_quot),
    .rsp_valid     (rsp_valid),
    .rsp_freq      (rsp_freq),
    .rsp_err       (rsp_err)
  );

  clkcalc_divider #(.W(WIDE_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (div_start),
    .dividend (div_dividend),
    .divisor  (div_divisor),
    .done     (div_done),
    .quotient (div_quot)
  );

endmodule

// File: rtl/clkcalc_chk.sv
module clkcalc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [2:0]  req_clk_id,
  input logic        rsp_valid,
  input logic [31:0] rsp_freq,
  input logic        rsp_err
);
  logic [2:0] seen_id;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_id <= 3'd0;
    else if (req_valid && req_ready) seen_id <= req_clk_id;
  end

  p_rsp_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_busy_after_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_no_ready_with_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  p_err_gives_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_freq == 32'd0));

  p_unsupported_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && seen_id >= 3'd5) |-> rsp_err);

  p_ref_clock_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && seen_id == 3'd3) |-> (rsp_freq == 32'd24000000 && !rsp_err));

  p_ref_div8_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && seen_id == 3'd4) |-> (rsp_freq == 32'd3000000 && !rsp_err));

  p_none_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && seen_id == 3'd0) |-> (rsp_freq == 32'd0 && !rsp_err));

endmodule

bind clkcalc_top clkcalc_chk u_chk (.*);

// File: tb/tb_clkcalc_top.sv
module tb_clkcalc_top;
  localparam int CLK_PERIOD = 10;
  localparam int FRAC_W = 6;
  localparam int DIV_W  = 3;
  localparam int WATCHDOG_CYCLES = 190000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [2:0]        req_clk_id = '0;
  logic              cfg_pll_mul22 = 1'b0;
  logic [FRAC_W-1:0] cfg_frac0 = '0;
  logic [FRAC_W-1:0] cfg_frac2 = '0;
  logic [1:0]        cfg_src_sel = '0;
  logic [DIV_W-1:0]  cfg_bus_div = '0;
  logic [DIV_W-1:0]  cfg_ipg_div = '0;
  logic [DIV_W-1:0]  cfg_per_div = '0;
  logic              rsp_valid;
  logic [31:0]       rsp_freq;
  logic              rsp_err;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkcalc_top #(.FRAC_W(FRAC_W), .DIV_W(DIV_W)) dut (.*);

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic logic [32:0] model(input logic [2:0] id, input logic m22,
      input logic [1:0] sel, input int f0, input int f2, input int a, input int b, input int c);
    logic [63:0] p;
    int f;
    if (id == 3'd0) return {1'b0, 32'd0};
    if (id == 3'd3) return {1'b0, 32'd24000000};
    if (id == 3'd4) return {1'b0, 32'd3000000};
    if (id > 3'd4) return {1'b1, 32'd0};
    p = 64'd24000000 * (m22 ? 64'd22 : 64'd20);
    if (sel != 2'd0) begin
      f = (sel == 2'd2) ? f0 : f2;
      if (f == 0) return {1'b1, 32'd0};
      p = (p * 64'd18) / 64'(f);
      if (sel == 2'd3) p = p / 64'd2;
    end
    p = p / 64'(a + 1);
    p = p / 64'(b + 1);
    if (id == 3'd2) p = p / 64'(c + 1);
    return {1'b0, p[31:0]};
  endfunction

  task automatic run_req(input logic [2:0] id, input logic m22, input logic [1:0] sel,
      input int f0, input int f2, input int a, input int b, input int c,
      output logic [31:0] freq, output logic err);
    int guard;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_clk_id = id; cfg_pll_mul22 = m22; cfg_src_sel = sel;
    cfg_frac0 = FRAC_W'(f0); cfg_frac2 = FRAC_W'(f2);
    cfg_bus_div = DIV_W'(a); cfg_ipg_div = DIV_W'(b); cfg_per_div = DIV_W'(c);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    guard = 0;
    while (!rsp_valid && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    freq = rsp_freq;
    err  = rsp_err;
  endtask

  task automatic expect_req(input string tag, input logic [2:0] id, input logic m22,
      input logic [1:0] sel, input int f0, input int f2, input int a, input int b, input int c);
    logic [31:0] fr;
    logic er;
    logic [32:0] e;
    e = model(id, m22, sel, f0, f2, a, b, c);
    run_req(id, m22, sel, f0, f2, a, b, c, fr, er);
    check({tag, " freq"}, fr, e[31:0]);
    check({tag, " err"}, 32'(er), 32'(e[32]));
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] fr;
    logic er;
    int pulses;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 ready", 32'(req_ready), 32'd1);
    check("R11 valid", 32'(rsp_valid), 32'd0);
    check("R11 freq", rsp_freq, 32'd0);
    check("R11 err", 32'(rsp_err), 32'd0);
    rst_n = 1'b1;

    // R1 PLL multiplier
    expect_req("R1 x20", 3'd1, 1'b0, 2'd0, 0, 0, 0, 0, 0);
    expect_req("R1 x22", 3'd1, 1'b1, 2'd0, 0, 0, 0, 0, 0);
    run_req(3'd1, 1'b1, 2'd0, 0, 0, 0, 0, 0, fr, er);
    check("R1 absolute", fr, 32'd528000000);

    // R5 constant identifiers, R6 unsupported
    expect_req("R5 none", 3'd0, 1'b1, 2'd1, 0, 0, 3, 3, 3);
    expect_req("R5 xtal", 3'd3, 1'b0, 2'd2, 0, 0, 0, 0, 0);
    expect_req("R5 xtal8", 3'd4, 1'b0, 2'd0, 1, 1, 7, 7, 7);
    for (int id = 5; id < 8; id++)
      expect_req("R6 unsupported", 3'(id), 1'b0, 2'd0, 5, 5, 0, 0, 0);

    // R2 R3 fraction sweep on every tapped source
    for (int f = 1; f < 64; f++) begin
      expect_req("R2 tap0", 3'd1, 1'b1, 2'd2, f, 33, 0, 0, 0);
      if (f % 8 == 3) begin
        expect_req("R3 tap2", 3'd1, 1'b0, 2'd1, 9, f, 0, 0, 0);
        expect_req("R3 tap2 half", 3'd1, 1'b1, 2'd3, 9, f, 0, 0, 0);
      end
    end

    // R3 R4 sweep of sources and post-dividers
    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 4; s++)
        for (int a = 0; a < 8; a++)
          for (int bi = 0; bi < 2; bi++)
            for (int ci = 0; ci < 2; ci++)
              expect_req("R4 cascade", 3'd2, 1'(m), 2'(s), 17, 23, a, bi * 5, ci * 7);
    expect_req("R4 ipg ignores per field", 3'd1, 1'b0, 2'd2, 19, 35, 2, 3, 6);

    // R7 zero fraction
    expect_req("R7 zero tap0", 3'd1, 1'b0, 2'd2, 0, 20, 0, 0, 0);
    expect_req("R7 zero tap2 half", 3'd2, 1'b1, 2'd3, 20, 0, 1, 1, 1);
    run_req(3'd1, 1'b0, 2'd1, 0, 24, 0, 0, 0, fr, er);
    check("R7 unselected zero err", 32'(er), 32'd0);
    check("R7 unselected zero freq", fr, 32'd360000000);

    // R8 truncation to 32 bits
    run_req(3'd1, 1'b1, 2'd2, 1, 1, 0, 0, 0, fr, er);
    check("R8 truncated", fr, 32'd914065408);

    // R9 R10 busy probes and snapshot
    @(negedge clk);
    req_clk_id = 3'd1; cfg_pll_mul22 = 1'b0; cfg_src_sel = 2'd0;
    cfg_bus_div = 3'd1; cfg_ipg_div = 3'd0; cfg_per_div = 3'd0;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R9 busy ready", 32'(req_ready), 32'd0);
    cfg_pll_mul22 = 1'b1; cfg_bus_div = 3'd7; req_clk_id = 3'd3;
    pulses = 0;
    for (int k = 0; k < 400; k++) begin
      req_valid = (k % 3 == 0) && !rsp_valid;
      if (rsp_valid) begin
        pulses++;
        fr = rsp_freq;
        er = rsp_err;
      end
      @(negedge clk);
      if (req_ready) break;
    end
    req_valid = 1'b0;
    check("R9 one pulse", 32'(pulses), 32'd1);
    check("R10 snapshot freq", fr, 32'd240000000);
    check("R10 snapshot err", 32'(er), 32'd0);
    repeat (3) @(negedge clk);
    check("R9 ignored request gives no response", 32'(rsp_valid), 32'd0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule